// File: doc/BRIEF.md
# Two-Beat Hash Request Sequencer

This block lets a requester in one clock domain obtain a digest from a hash engine that runs on an unrelated clock. The requester raises a level request. The block carries the request into the engine domain and sends the engine a fixed message of two data words over a valid/ready channel, with the second word marked as the last one. It then waits for the engine's done flag, takes the engine's result, and returns that result to the requester domain through a four-phase request/acknowledge crossing.

On the requester side, the acknowledge and the result are latched together. After that, the forwarded request is masked, so a request input that stays high does not start a second exchange. The engine-side sequencer ends in a terminal state. Only a reset of the engine domain lets it run again. Each domain has its own active-low asynchronous reset.

Top module: `hash_seq_bridge`

## Requirements
- R1: After a requester-domain reset, `ack_o` is 0 and `result_o` is 0. After an engine-domain reset, `eng_valid_o` is 0 until a synchronized request arrives.
- R2: In the first-beat phase, a synchronized request drives `eng_valid_o`=1, `eng_last_o`=0 and `eng_data_o`=WORD0. This holds for as long as `eng_ready_i` stays low.
- R3: When `eng_ready_i` is high in a cycle that offers the first beat, the next engine cycle offers `eng_valid_o`=1, `eng_last_o`=1 and `eng_data_o`=WORD1. This holds until `eng_ready_i` is seen.
- R4: The engine cycle after the second beat is accepted, `eng_valid_o` is 0. It stays 0, and `ack_o` stays 0, until `eng_done_i` is seen.
- R5: The value on `eng_result_i` in the cycle in which `eng_done_i` is high is the value that later appears on `result_o`. It appears in the same requester cycle in which `ack_o` rises, and `ack_o` rises only while `req_i` is high.
- R6: Once `ack_o` is 1, it stays 1 and `result_o` stays constant until a requester-domain reset. While `ack_o` is 1, the request is masked, so the engine sees no new beats even after an engine-domain reset.
- R7: After `eng_done_i`, the sequencer stays in its terminal state: pulses on `eng_ready_i` and `eng_done_i` produce no valid beat. After resets of both domains, a held request runs a complete new exchange with a new result.
- R8: An engine-domain reset during the second beat or during the wait for done returns the sequencer to the first beat. If the request is still held, WORD0 is offered again with `eng_last_o`=0.
- R9: While `eng_valid_o` is 1 and `eng_ready_i` is 0, `eng_data_o` and `eng_last_o` keep their values into the next engine cycle.
- R10: With `req_i` low, `eng_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req_i | input | 1 | Requester-domain clock |
| rst_req_ni | input | 1 | Requester-domain active-low asynchronous reset |
| req_i | input | 1 | Level request for a digest |
| ack_o | output | 1 | Sticky acknowledge, latched together with the result |
| result_o | output | RES_W | Latched digest returned to the requester |
| clk_eng_i | input | 1 | Hash-engine clock |
| rst_eng_ni | input | 1 | Hash-engine active-low asynchronous reset |
| eng_valid_o | output | 1 | Data word valid toward the engine |
| eng_last_o | output | 1 | Marks the second and final beat |
| eng_data_o | output | DATA_W | Message word toward the engine |
| eng_ready_i | input | 1 | Engine accepts the offered word |
| eng_done_i | input | 1 | Engine reports the digest is ready |
| eng_result_i | input | RES_W | Digest from the engine, sampled with done |

## Verification
Results inside the engine domain are due exactly one engine cycle after the stimulus. This covers the beat that follows an accepted ready and the drop of valid after the last beat, so the bench drives engine inputs on a falling edge and checks the next falling edge. Results that cross a domain have no fixed cycle. A request reaches the engine after two synchronizer flops, within three engine cycles. The acknowledge returns after one engine cycle for the result capture, one more for the handshake level, and then two synchronizer flops plus one latch in the requester domain. The bench therefore polls these results against a bound (12 engine cycles or 40 requester cycles) and then compares the value exactly. The "nothing happens" windows are checked on every cycle over a fixed span.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    // Sequencer phases; 3-bit one-hot-ish codes leave spare encodings
    // that the default branch catches.
    typedef enum logic [2:0] {
        SEQ_FIRST  = 3'b001,
        SEQ_SECOND = 3'b010,
        SEQ_WAIT   = 3'b100,
        SEQ_DONE   = 3'b111
    } seq_state_e;

endpackage

// File: rtl/hsb_sync2.sv
module hsb_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/hsb_reqack_xfer.sv
module hsb_reqack_xfer #(
    parameter int WIDTH = 32
) (
    input  logic             clk_src,
    input  logic             rst_src_n,
    input  logic             src_req_i,
    output logic             src_ack_o,
    output logic [WIDTH-1:0] src_data_o,
    input  logic             clk_dst,
    input  logic             rst_dst_n,
    output logic             dst_req_o,
    input  logic             dst_ack_i,
    input  logic [WIDTH-1:0] dst_data_i
);
    typedef struct packed {
        logic             ack_lvl;
        logic [WIDTH-1:0] data;
    } dst_regs_t;

    dst_regs_t r_d, r_q;
    logic      req_sync;
    logic      ack_sync;

    hsb_sync2 #(.WIDTH(1)) i_req_sync (
        .clk   (clk_dst),
        .rst_n (rst_dst_n),
        .d_i   (src_req_i),
        .q_o   (req_sync)
    );

    hsb_sync2 #(.WIDTH(1)) i_ack_sync (
        .clk   (clk_src),
        .rst_n (rst_src_n),
        .d_i   (r_q.ack_lvl),
        .q_o   (ack_sync)
    );

    // Four-phase destination side: raise the level with data held,
    // drop it once the source request has been withdrawn.
    always_comb begin
        r_d = r_q;
        if (!r_q.ack_lvl && req_sync && dst_ack_i) begin
            r_d.ack_lvl = 1'b1;
            r_d.data    = dst_data_i;
        end else if (r_q.ack_lvl && !req_sync) begin
            r_d.ack_lvl = 1'b0;
        end
    end

    always_ff @(posedge clk_dst or negedge rst_dst_n) begin
        if (!rst_dst_n) begin
            r_q <= '{ack_lvl: 1'b0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dst_req_o  = req_sync & ~r_q.ack_lvl;
    assign src_ack_o  = src_req_i & ack_sync;
    assign src_data_o = r_q.data;

    // The returned level only rises in answer to a synchronized request.
    assert_ack_follows_req_R5: assert property (
        @(posedge clk_dst) disable iff (!rst_dst_n)
        $rose(r_q.ack_lvl) |-> $past(req_sync)
    );

    // Data crossing unsynchronized must not move while the level is up.
    assert_data_held_R5: assert property (
        @(posedge clk_dst) disable iff (!rst_dst_n)
        r_q.ack_lvl |=> (!r_q.ack_lvl || $stable(r_q.data))
    );
endmodule

// File: rtl/hsb_seq.sv
module hsb_seq
    import hsb_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter int                RES_W  = 32,
    parameter logic [DATA_W-1:0] WORD0  = '0,
    parameter logic [DATA_W-1:0] WORD1  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              ready_i,
    input  logic              done_i,
    input  logic [RES_W-1:0]  result_i,
    output logic              valid_o,
    output logic              last_o,
    output logic [DATA_W-1:0] data_o,
    output logic [RES_W-1:0]  res_o,
    output logic              fin_o
);
    typedef struct packed {
        seq_state_e       st;
        logic [RES_W-1:0] res;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        valid_o = 1'b0;
        last_o  = 1'b0;
        data_o  = WORD0;
        unique case (r_q.st)
            SEQ_FIRST: begin
                valid_o = req_i;
                if (req_i && ready_i) begin
                    r_d.st = SEQ_SECOND;
                end
            end
            SEQ_SECOND: begin
                valid_o = 1'b1;
                last_o  = 1'b1;
                data_o  = WORD1;
                if (ready_i) begin
                    r_d.st = SEQ_WAIT;
                end
            end
            SEQ_WAIT: begin
                if (done_i) begin
                    r_d.res = result_i;
                    r_d.st  = SEQ_DONE;
                end
            end
            SEQ_DONE: begin
                r_d = r_q;
            end
            default: begin
                r_d.st  = SEQ_FIRST;
                r_d.res = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SEQ_FIRST, res: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign res_o = r_q.res;
    assign fin_o = (r_q.st == SEQ_DONE);

    assert_data_stable_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> ($stable(data_o) && $stable(last_o))
    );

    assert_done_terminal_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        fin_o |=> fin_o
    );

    assert_no_beat_after_last_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && ready_i) |=> !valid_o
    );
endmodule

// File: rtl/hash_seq_bridge.sv
module hash_seq_bridge #(
    parameter int                DATA_W = 32,
    parameter int                RES_W  = 32,
    parameter logic [DATA_W-1:0] WORD0  = 32'h4D53_0001,
    parameter logic [DATA_W-1:0] WORD1  = 32'h4D53_0002
) (
    input  logic              clk_req_i,
    input  logic              rst_req_ni,
    input  logic              req_i,
    output logic              ack_o,
    output logic [RES_W-1:0]  result_o,
    input  logic              clk_eng_i,
    input  logic              rst_eng_ni,
    output logic              eng_valid_o,
    output logic              eng_last_o,
    output logic [DATA_W-1:0] eng_data_o,
    input  logic              eng_ready_i,
    input  logic              eng_done_i,
    input  logic [RES_W-1:0]  eng_result_i
);
    typedef struct packed {
        logic             ack;
        logic [RES_W-1:0] res;
    } req_regs_t;

    req_regs_t        r_d, r_q;
    logic             fwd_req;
    logic             xfer_ack;
    logic [RES_W-1:0] xfer_data;
    logic             eng_req;
    logic             seq_fin;
    logic [RES_W-1:0] seq_res;

    // A completed request is never forwarded again while req_i stays high.
    assign fwd_req = req_i & ~r_q.ack;

    hsb_reqack_xfer #(.WIDTH(RES_W)) i_xfer (
        .clk_src    (clk_req_i),
        .rst_src_n  (rst_req_ni),
        .src_req_i  (fwd_req),
        .src_ack_o  (xfer_ack),
        .src_data_o (xfer_data),
        .clk_dst    (clk_eng_i),
        .rst_dst_n  (rst_eng_ni),
        .dst_req_o  (eng_req),
        .dst_ack_i  (seq_fin),
        .dst_data_i (seq_res)
    );

    hsb_seq #(
        .DATA_W (DATA_W),
        .RES_W  (RES_W),
        .WORD0  (WORD0),
        .WORD1  (WORD1)
    ) i_seq (
        .clk      (clk_eng_i),
        .rst_n    (rst_eng_ni),
        .req_i    (eng_req),
        .ready_i  (eng_ready_i),
        .done_i   (eng_done_i),
        .result_i (eng_result_i),
        .valid_o  (eng_valid_o),
        .last_o   (eng_last_o),
        .data_o   (eng_data_o),
        .res_o    (seq_res),
        .fin_o    (seq_fin)
    );

    always_comb begin
        r_d = r_q;
        if (req_i && xfer_ack) begin
            r_d.ack = 1'b1;
            r_d.res = xfer_data;
        end
    end

    always_ff @(posedge clk_req_i or negedge rst_req_ni) begin
        if (!rst_req_ni) begin
            r_q <= '{ack: 1'b0, res: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o    = r_q.ack;
    assign result_o = r_q.res;

    assert_ack_sticky_R6: assert property (
        @(posedge clk_req_i) disable iff (!rst_req_ni)
        ack_o |=> (ack_o && $stable(result_o))
    );

    assert_ack_needs_req_R5: assert property (
        @(posedge clk_req_i) disable iff (!rst_req_ni)
        $rose(ack_o) |-> $past(req_i)
    );
endmodule

// File: tb/test_hash_seq_bridge.sv
module test_hash_seq_bridge;
    localparam logic [31:0] W0 = 32'h6C63_0001;
    localparam logic [31:0] W1 = 32'h6C63_0002;

    logic        clk_req = 1'b0;
    logic        clk_eng = 1'b0;
    logic        rst_req_n, rst_eng_n;
    logic        req, ack;
    logic [31:0] result;
    logic        valid, last;
    logic [31:0] data;
    logic        ready, done;
    logic [31:0] eng_res;

    int checks = 0;
    int fails  = 0;

    always #10 clk_req = ~clk_req;   // 50 MHz
    always #7  clk_eng = ~clk_eng;   // unrelated engine clock

    hash_seq_bridge #(.DATA_W(32), .RES_W(32), .WORD0(W0), .WORD1(W1)) i_hash_seq_bridge (
        .clk_req_i    (clk_req),
        .rst_req_ni   (rst_req_n),
        .req_i        (req),
        .ack_o        (ack),
        .result_o     (result),
        .clk_eng_i    (clk_eng),
        .rst_eng_ni   (rst_eng_n),
        .eng_valid_o  (valid),
        .eng_last_o   (last),
        .eng_data_o   (data),
        .eng_ready_i  (ready),
        .eng_done_i   (done),
        .eng_result_i (eng_res)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic reset_all();
        req = 0; ready = 0; done = 0; eng_res = '0;
        rst_req_n = 0; rst_eng_n = 0;
        repeat (4) @(negedge clk_req);
        @(negedge clk_eng); rst_eng_n = 1;
        @(negedge clk_req); rst_req_n = 1;
        repeat (2) @(negedge clk_req);
    endtask

    task automatic wait_valid(output bit seen);
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk_eng);
            if (valid) begin seen = 1; break; end
        end
    endtask

    task automatic wait_ack(output bit seen);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_req);
            if (ack) begin seen = 1; break; end
        end
    endtask

    // Full exchange; ends with the result latched on the requester side.
    task automatic run_exchange(input logic [31:0] rv);
        bit seen, bad;
        @(negedge clk_req); req = 1;
        wait_valid(seen);
        chk(seen, "R2 first beat valid", {31'd0, valid}, 32'd1);
        chk(data == W0 && !last, "R2 first beat word", data, W0);
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_eng);
            if (!valid || data != W0 || last) bad = 1;
        end
        chk(!bad, "R9 first beat held", data, W0);
        ready = 1;
        @(negedge clk_eng); ready = 0;
        chk(valid && last && data == W1, "R3 second beat", data, W1);
        bad = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk_eng);
            if (!valid || !last || data != W1) bad = 1;
        end
        chk(!bad, "R9 second beat held", data, W1);
        ready = 1;
        @(negedge clk_eng); ready = 0;
        chk(!valid, "R4 valid drops after last", {31'd0, valid}, 32'd0);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_eng);
            if (valid || ack) bad = 1;
        end
        chk(!bad, "R4 waiting for done", {31'd0, ack}, 32'd0);
        eng_res = rv; done = 1;
        @(negedge clk_eng); done = 0; eng_res = ~rv;
        wait_ack(seen);
        chk(seen, "R5 ack arrives", {31'd0, ack}, 32'd1);
        chk(result == rv, "R5 result value", result, rv);
    endtask

    task automatic t_reset();
        reset_all();
        chk(ack == 0, "R1 ack after reset", {31'd0, ack}, 32'd0);
        chk(result == 0, "R1 result after reset", result, 32'd0);
        chk(valid == 0, "R1 valid after reset", {31'd0, valid}, 32'd0);
    endtask

    task automatic t_idle();
        bit bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_eng);
            if (valid) bad = 1;
        end
        chk(!bad, "R10 no request no valid", {31'd0, bad}, 32'd0);
    endtask

    task automatic t_full_and_terminal();
        bit bad = 0;
        logic [31:0] held;
        reset_all();
        run_exchange(32'hC0FF_EE01);
        held = result;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_eng);
            if (valid || !ack || result != held) bad = 1;
        end
        chk(!bad, "R6 ack and result sticky", result, held);
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk_eng); ready = 1; done = 1;
            @(negedge clk_eng); ready = 0; done = 0;
            if (valid) bad = 1;
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_eng);
            if (valid) bad = 1;
        end
        chk(!bad, "R7 terminal state ignores ready/done", {31'd0, bad}, 32'd0);
    endtask

    task automatic t_restart();
        bit bad = 0;
        // Engine reset only: request still masked by the latched ack.
        @(negedge clk_eng); rst_eng_n = 0;
        repeat (3) @(negedge clk_eng);
        rst_eng_n = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_eng);
            if (valid) bad = 1;
        end
        chk(!bad, "R6 masked request after engine reset", {31'd0, bad}, 32'd0);
        chk(ack == 1 && result == 32'hC0FF_EE01, "R6 ack kept over engine reset", result, 32'hC0FF_EE01);
        @(negedge clk_req); rst_req_n = 0;
        repeat (2) @(negedge clk_req);
        chk(ack == 0 && result == 0, "R1 requester reset clears", result, 32'd0);
        rst_req_n = 1;
        run_exchange(32'h1234_5678);
        chk(result == 32'h1234_5678, "R7 second exchange after resets", result, 32'h1234_5678);
    endtask

    task automatic t_reset_mid();
        bit seen;
        reset_all();
        @(negedge clk_req); req = 1;
        wait_valid(seen);
        ready = 1;
        @(negedge clk_eng); ready = 0;
        chk(valid && last, "R3 reached second beat", {31'd0, last}, 32'd1);
        rst_eng_n = 0;
        repeat (2) @(negedge clk_eng);
        rst_eng_n = 1;
        wait_valid(seen);
        chk(seen && data == W0 && !last, "R8 reset in second beat", data, W0);
        ready = 1;
        repeat (2) @(negedge clk_eng);
        ready = 0;
        chk(!valid, "R4 in wait after two accepts", {31'd0, valid}, 32'd0);
        rst_eng_n = 0;
        repeat (2) @(negedge clk_eng);
        rst_eng_n = 1;
        wait_valid(seen);
        chk(seen && data == W0 && !last, "R8 reset in wait", data, W0);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_full_and_terminal();
        t_restart();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule